// File: doc/BRIEF.md
# Recency-Ordered Fully Associative Translation Buffer

The block is a small fully associative address translation buffer. Its entries are stored as a list ordered by recency: slot 0 holds the most recently used translation and the last slot the least recently used one. A lookup port takes a virtual page number and a context identifier. In the same cycle it returns a hit flag, the list position of the winning entry, the physical frame number and the attribute bits.

The list order is kept physically, not through side bookkeeping. A fill writes a new translation into slot 0, moves every other entry one slot toward the tail and discards the entry in the last slot. A lookup hit deeper in the list than a small protected window moves the hit entry to slot 0 and moves the entries in front of it down by one. Hits inside the window leave the order alone. This saves shifting work on the entries that are already hot. A flush empties the whole table.

Each entry carries a page-size shift, so one entry can cover a power-of-two range of page numbers. It also carries a global flag, which makes the entry match any context.

Top module: `recency_tlb`

## Requirements
- R1: Lookup results (`lk_hit_o`, `lk_idx_o`, `lk_pfn_o`, `lk_attr_o`) are combinational in the request cycle. When several entries match, the one in the lowest slot wins, and `lk_idx_o` is that slot number.
- R2: An entry matches when all three of these hold: it is valid; its VPN equals `lk_vpn_i` on every bit at position N or above, where N is the entry's page-size shift; and either its ASID equals `lk_ctx_i` or its global flag is set.
- R3: On a miss, `lk_hit_o`, `lk_idx_o`, `lk_pfn_o` and `lk_attr_o` are all zero.
- R4: A hit at slot x greater than HOLD_WIN (default 1), with `lk_valid_i` high, takes effect at the next clock edge. The hit entry moves to slot 0 and the entries in slots 0 to x-1 each move down one slot. This includes a hit in the last slot.
- R5: A hit at a slot less than or equal to HOLD_WIN leaves the list order unchanged.
- R6: A fill writes {valid=1, the fill fields} into slot 0 at the next edge. Every entry moves down one slot, and the entry in the last slot is discarded. `fill_attr_i` is returned unchanged on `lk_attr_o`. With the defaults its layout is: bit 7 non-cacheable, bit 6 execute-never, bits 5:4 access permission, bits 3:0 domain.
- R7: A flush invalidates and zeroes every entry at the next edge. A lookup in the following cycle misses.
- R8: When operations fall in the same cycle, flush beats fill, and fill beats a promotion. The losing operation has no effect.
- R9: Synchronous active-low reset leaves the table empty, so every lookup misses.
- R10: With `lk_valid_i` low, lookup results are still reported, but the list order does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| fill_i | input | 1 | Insert a translation at the head |
| fill_vpn_i | input | VPN_W | Virtual page number of the new entry |
| fill_asid_i | input | ASID_W | Address-space identifier of the new entry |
| fill_pfn_i | input | PFN_W | Physical frame number of the new entry |
| fill_shift_i | input | SHIFT_W | Page-size shift N of the new entry |
| fill_global_i | input | 1 | New entry matches any context |
| fill_attr_i | input | ATTR_W | Attribute bits of the new entry |
| lk_valid_i | input | 1 | Lookup is a real access (allows promotion) |
| lk_vpn_i | input | VPN_W | Lookup virtual page number |
| lk_ctx_i | input | ASID_W | Lookup context identifier |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | IDX_W | Slot of the winning entry |
| lk_pfn_o | output | PFN_W | Frame number of the winning entry |
| lk_attr_o | output | ATTR_W | Attributes of the winning entry |

## Verification
The assertions check the following on every cycle:
- a flush leaves the whole table zero;
- a fill places the new entry at the head and the old second-to-last entry in the last slot;
- a promotion brings the hit entry to the head;
- a hit inside the window, or an idle probe, leaves the stored list untouched;
- the reported slot really is the first match.

Only the bench's scenarios can show that the whole list order follows the recency rules over long sequences of hits and fills. They probe every live entry after each operation. The same holds for large-page and global matching, eviction from a full table, and the outcome of colliding fill, flush and promotion requests.

// File: rtl/rtlb_pkg.sv
// Shared definitions for the recency-ordered translation buffer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rtlb_pkg;

    // Operation applied to the entry list at the next clock edge.
    typedef enum logic [1:0] {
        LIST_HOLD    = 2'd0,
        LIST_PROMOTE = 2'd1,
        LIST_FILL    = 2'd2,
        LIST_FLUSH   = 2'd3
    } list_op_e;

endpackage

// File: rtl/rtlb_match.sv
// Parallel tag comparators plus a lowest-slot priority encoder.
// Assumes ENTRIES >= 2 and that a page-size shift never exceeds VPN_W.
module rtlb_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int SHIFT_W = 3,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]              ent_valid,
    input  logic [ENTRIES-1:0]              ent_global,
    input  logic [ENTRIES-1:0][VPN_W-1:0]   ent_vpn,
    input  logic [ENTRIES-1:0][SHIFT_W-1:0] ent_shift,
    input  logic [ENTRIES-1:0][ASID_W-1:0]  ent_asid,
    input  logic [VPN_W-1:0]                req_vpn,
    input  logic [ASID_W-1:0]               req_ctx,
    output logic [ENTRIES-1:0]              match_vec,
    output logic                            hit,
    output logic [IDX_W-1:0]                idx
);

    // One comparator per slot; bits below the entry's shift are don't-care.
    for (genvar k = 0; k < ENTRIES; k++) begin : g_cmp
        logic [VPN_W-1:0] care;
        logic             vpn_eq;
        logic             ctx_ok;
        assign care   = {VPN_W{1'b1}} << ent_shift[k];
        assign vpn_eq = ((ent_vpn[k] ^ req_vpn) & care) == '0;
        assign ctx_ok = ent_global[k] || (ent_asid[k] == req_ctx);
        assign match_vec[k] = ent_valid[k] && vpn_eq && ctx_ok;
    end

    // Pick the lowest matching slot (scan from the tail, last write wins).
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (match_vec[k]) begin
                hit = 1'b1;
                idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/rtlb_ctrl.sv
// Decides which list operation commits at the next edge.
// Priority: flush, then fill, then promotion of a deep hit.
// Assumes HOLD_WIN >= 0; values past the last slot disable promotion.
module rtlb_ctrl
    import rtlb_pkg::*;
#(
    parameter int ENTRIES  = 8,
    parameter int HOLD_WIN = 1,
    parameter int IDX_W    = $clog2(ENTRIES)
) (
    input  logic             flush_i,
    input  logic             fill_i,
    input  logic             lk_valid_i,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] idx_i,
    output list_op_e         op_o,
    output logic [IDX_W-1:0] src_o
);

    localparam int WIN_CLAMP = (HOLD_WIN > ENTRIES - 1) ? ENTRIES - 1 : HOLD_WIN;
    localparam logic [IDX_W-1:0] WIN_IDX = IDX_W'(WIN_CLAMP);

    logic deep_hit;

    // A real access that hits beyond the protected window asks for promotion.
    assign deep_hit = lk_valid_i && hit_i && (idx_i > WIN_IDX);

    // Resolve competing requests into a single list operation.
    always_comb begin
        if (flush_i)       op_o = LIST_FLUSH;
        else if (fill_i)   op_o = LIST_FILL;
        else if (deep_hit) op_o = LIST_PROMOTE;
        else               op_o = LIST_HOLD;
    end

    // The promoted entry is always the current lookup winner.
    assign src_o = idx_i;

endmodule

// File: rtl/rtlb_store.sv
// Recency-ordered entry storage: slot 0 is most recent.
// Every slot takes its next value from itself, its upper neighbour,
// the fill data or the promoted slot. Entries are opaque ENT_W vectors.
// Assumes ENTRIES >= 2.
module rtlb_store
    import rtlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ENT_W   = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  list_op_e                      op,
    input  logic [IDX_W-1:0]              src_idx,
    input  logic [ENT_W-1:0]              new_ent,
    output logic [ENTRIES-1:0][ENT_W-1:0] slots
);

    logic [ENTRIES-1:0][ENT_W-1:0] q;
    logic [ENTRIES-1:0][ENT_W-1:0] nxt;

    // Per-slot next-state selection.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        if (i == 0) begin : g_head
            assign nxt[i] = (op == LIST_FLUSH)   ? '0 :
                            (op == LIST_FILL)    ? new_ent :
                            (op == LIST_PROMOTE) ? q[src_idx] :
                                                   q[i];
        end else begin : g_body
            logic in_shift;
            assign in_shift = (op == LIST_FILL) ||
                              ((op == LIST_PROMOTE) && (IDX_W'(i) <= src_idx));
            assign nxt[i] = (op == LIST_FLUSH) ? '0 :
                            in_shift           ? q[i-1] :
                                                 q[i];
        end
    end

    // Commit the whole list on the clock edge; reset empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    assign slots = q;

    assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LIST_FLUSH) |=> (q == '0));

    assert_fill_tail_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LIST_FILL) |=> (q[ENTRIES-1] == $past(q[ENTRIES-2])));

    assert_promote_to_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LIST_PROMOTE) |=> (q[0] == $past(q[src_idx])));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LIST_HOLD) |=> $stable(q));

endmodule

// File: rtl/recency_tlb.sv
// Fully associative translation buffer whose entries are physically kept
// in recency order. Lookup is combinational; list updates commit at the
// next edge. Assumes ENTRIES >= 2 and entry shifts below VPN_W.
module recency_tlb
    import rtlb_pkg::*;
#(
    parameter int  ENTRIES  = 8,
    parameter int  VPN_W    = 20,
    parameter int  PFN_W    = 20,
    parameter int  ASID_W   = 8,
    parameter int  SHIFT_W  = 3,
    parameter int  PERM_W   = 2,
    parameter int  DOM_W    = 4,
    parameter int  HOLD_WIN = 1,
    localparam int ATTR_W   = 2 + PERM_W + DOM_W,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               fill_i,
    input  logic [VPN_W-1:0]   fill_vpn_i,
    input  logic [ASID_W-1:0]  fill_asid_i,
    input  logic [PFN_W-1:0]   fill_pfn_i,
    input  logic [SHIFT_W-1:0] fill_shift_i,
    input  logic               fill_global_i,
    input  logic [ATTR_W-1:0]  fill_attr_i,
    input  logic               lk_valid_i,
    input  logic [VPN_W-1:0]   lk_vpn_i,
    input  logic [ASID_W-1:0]  lk_ctx_i,
    output logic               lk_hit_o,
    output logic [IDX_W-1:0]   lk_idx_o,
    output logic [PFN_W-1:0]   lk_pfn_o,
    output logic [ATTR_W-1:0]  lk_attr_o
);

    // Entry layout, LSB upward.
    localparam int ATTR_LO  = 0;
    localparam int PFN_LO   = ATTR_LO + ATTR_W;
    localparam int VPN_LO   = PFN_LO + PFN_W;
    localparam int SHIFT_LO = VPN_LO + VPN_W;
    localparam int ASID_LO  = SHIFT_LO + SHIFT_W;
    localparam int GLB_BIT  = ASID_LO + ASID_W;
    localparam int VLD_BIT  = GLB_BIT + 1;
    localparam int ENT_W    = VLD_BIT + 1;
    localparam int WIN_CLAMP = (HOLD_WIN > ENTRIES - 1) ? ENTRIES - 1 : HOLD_WIN;

    logic [ENTRIES-1:0][ENT_W-1:0]   slot_q;
    logic [ENTRIES-1:0]              e_valid;
    logic [ENTRIES-1:0]              e_global;
    logic [ENTRIES-1:0][VPN_W-1:0]   e_vpn;
    logic [ENTRIES-1:0][SHIFT_W-1:0] e_shift;
    logic [ENTRIES-1:0][ASID_W-1:0]  e_asid;
    logic [ENTRIES-1:0][PFN_W-1:0]   e_pfn;
    logic [ENTRIES-1:0][ATTR_W-1:0]  e_attr;
    logic [ENTRIES-1:0]              match_vec;
    logic                            hit;
    logic [IDX_W-1:0]                idx;
    logic [ENT_W-1:0]                new_ent;
    list_op_e                        op;
    logic [IDX_W-1:0]                src_idx;

    // Split each stored vector into its fields.
    for (genvar k = 0; k < ENTRIES; k++) begin : g_unpack
        assign e_valid[k]  = slot_q[k][VLD_BIT];
        assign e_global[k] = slot_q[k][GLB_BIT];
        assign e_asid[k]   = slot_q[k][ASID_LO  +: ASID_W];
        assign e_shift[k]  = slot_q[k][SHIFT_LO +: SHIFT_W];
        assign e_vpn[k]    = slot_q[k][VPN_LO   +: VPN_W];
        assign e_pfn[k]    = slot_q[k][PFN_LO   +: PFN_W];
        assign e_attr[k]   = slot_q[k][ATTR_LO  +: ATTR_W];
    end

    // Assemble the entry written by a fill; it is always valid.
    assign new_ent = {1'b1, fill_global_i, fill_asid_i, fill_shift_i,
                      fill_vpn_i, fill_pfn_i, fill_attr_i};

    rtlb_match #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .ASID_W  (ASID_W),
        .SHIFT_W (SHIFT_W),
        .IDX_W   (IDX_W)
    ) u_match (
        .ent_valid  (e_valid),
        .ent_global (e_global),
        .ent_vpn    (e_vpn),
        .ent_shift  (e_shift),
        .ent_asid   (e_asid),
        .req_vpn    (lk_vpn_i),
        .req_ctx    (lk_ctx_i),
        .match_vec  (match_vec),
        .hit        (hit),
        .idx        (idx)
    );

    rtlb_ctrl #(
        .ENTRIES  (ENTRIES),
        .HOLD_WIN (HOLD_WIN),
        .IDX_W    (IDX_W)
    ) u_ctrl (
        .flush_i    (flush_i),
        .fill_i     (fill_i),
        .lk_valid_i (lk_valid_i),
        .hit_i      (hit),
        .idx_i      (idx),
        .op_o       (op),
        .src_o      (src_idx)
    );

    rtlb_store #(
        .ENTRIES (ENTRIES),
        .ENT_W   (ENT_W),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .src_idx (src_idx),
        .new_ent (new_ent),
        .slots   (slot_q)
    );

    // Drive the lookup result; a miss returns all zeros.
    always_comb begin
        lk_hit_o  = hit;
        lk_idx_o  = hit ? idx       : '0;
        lk_pfn_o  = hit ? e_pfn[idx]  : '0;
        lk_attr_o = hit ? e_attr[idx] : '0;
    end

    assert_first_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit_o |-> (match_vec[lk_idx_o] &&
                      ((match_vec & ((ENTRIES)'(1) << lk_idx_o) - (ENTRIES)'(1)) == '0)));

    assert_window_no_reorder_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid_i && lk_hit_o && (int'(lk_idx_o) <= WIN_CLAMP) && !fill_i && !flush_i)
        |=> $stable(slot_q));

    assert_fill_beats_promote_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && !flush_i) |=> (slot_q[0] == $past(new_ent)));

    assert_idle_probe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_valid_i && !fill_i && !flush_i) |=> $stable(slot_q));

endmodule

// File: tb/tb_recency_tlb.sv
module tb_recency_tlb;

    localparam int CLK_PERIOD = 10;
    localparam int E   = 8;
    localparam int WIN = 1;

    typedef struct packed {
        logic [1:0]  kind;   // 0 lookup, 1 fill, 2 flush
        logic [19:0] vpn;
        logic [7:0]  asid;   // lookup context or fill ASID
        logic [19:0] pfn;
        logic [2:0]  shift;
        logic        glob;
        logic [7:0]  attr;
        logic        exp_hit;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 20'h0,     8'h0,  20'h0,     3'd0, 1'b0, 8'h00, 1'b0},
        '{2'd1, 20'h00100, 8'h01, 20'h00800, 3'd0, 1'b0, 8'h10, 1'b0},
        '{2'd1, 20'h00101, 8'h01, 20'h00801, 3'd0, 1'b0, 8'h11, 1'b0},
        '{2'd1, 20'h00102, 8'h01, 20'h00802, 3'd0, 1'b0, 8'h12, 1'b0},
        '{2'd1, 20'h00103, 8'h01, 20'h00803, 3'd0, 1'b0, 8'h13, 1'b0},
        '{2'd1, 20'h00104, 8'h01, 20'h00804, 3'd0, 1'b0, 8'h14, 1'b0},
        '{2'd1, 20'h00105, 8'h01, 20'h00805, 3'd0, 1'b0, 8'h15, 1'b0},
        '{2'd1, 20'h00106, 8'h01, 20'h00806, 3'd0, 1'b0, 8'h16, 1'b0},
        '{2'd1, 20'h00107, 8'h01, 20'h00807, 3'd0, 1'b0, 8'h17, 1'b0},
        '{2'd0, 20'h00100, 8'h01, 20'h0,     3'd0, 1'b0, 8'h00, 1'b1}, // last slot, R4
        '{2'd0, 20'h00107, 8'h01, 20'h0,     3'd0, 1'b0, 8'h00, 1'b1}, // slot 1 boundary, R5
        '{2'd0, 20'h00106, 8'h01, 20'h0,     3'd0, 1'b0, 8'h00, 1'b1}, // slot 2, R4
        '{2'd0, 20'h00103, 8'h02, 20'h0,     3'd0, 1'b0, 8'h00, 1'b0}, // wrong ctx, R2
        '{2'd1, 20'h00200, 8'h05, 20'h00900, 3'd0, 1'b1, 8'hC5, 1'b0}, // full table, R6
        '{2'd0, 20'h00200, 8'h09, 20'h0,     3'd0, 1'b0, 8'h00, 1'b1}, // global, R2
        '{2'd0, 20'h00101, 8'h01, 20'h0,     3'd0, 1'b0, 8'h00, 1'b0}, // evicted, R6
        '{2'd1, 20'h00340, 8'h03, 20'h00A00, 3'd4, 1'b0, 8'h3A, 1'b0},
        '{2'd0, 20'h0034F, 8'h03, 20'h0,     3'd0, 1'b0, 8'h00, 1'b1}, // large page, R2
        '{2'd0, 20'h00350, 8'h03, 20'h0,     3'd0, 1'b0, 8'h00, 1'b0},
        '{2'd0, 20'h00103, 8'h01, 20'h0,     3'd0, 1'b0, 8'h00, 1'b1}, // last slot, R4
        '{2'd2, 20'h0,     8'h0,  20'h0,     3'd0, 1'b0, 8'h00, 1'b0},
        '{2'd0, 20'h00100, 8'h01, 20'h0,     3'd0, 1'b0, 8'h00, 1'b0}  // after flush, R7
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush_i, fill_i, fill_global_i, lk_valid_i;
    logic [19:0] fill_vpn_i, fill_pfn_i, lk_vpn_i;
    logic [7:0]  fill_asid_i, lk_ctx_i, fill_attr_i;
    logic [2:0]  fill_shift_i;
    logic        lk_hit_o;
    logic [2:0]  lk_idx_o;
    logic [19:0] lk_pfn_o;
    logic [7:0]  lk_attr_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference list, slot 0 most recent.
    logic        m_valid [E];
    logic        m_glob  [E];
    logic [19:0] m_vpn   [E];
    logic [19:0] m_pfn   [E];
    logic [7:0]  m_asid  [E];
    logic [2:0]  m_shift [E];
    logic [7:0]  m_attr  [E];

    recency_tlb dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .fill_i(fill_i),
        .fill_vpn_i(fill_vpn_i), .fill_asid_i(fill_asid_i), .fill_pfn_i(fill_pfn_i),
        .fill_shift_i(fill_shift_i), .fill_global_i(fill_global_i),
        .fill_attr_i(fill_attr_i), .lk_valid_i(lk_valid_i), .lk_vpn_i(lk_vpn_i),
        .lk_ctx_i(lk_ctx_i), .lk_hit_o(lk_hit_o), .lk_idx_o(lk_idx_o),
        .lk_pfn_o(lk_pfn_o), .lk_attr_o(lk_attr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        summary();
    end

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic vec_t mk(logic [19:0] vpn, logic [7:0] asid, logic [19:0] pfn,
                                logic [2:0] sh, logic g, logic [7:0] at, logic eh);
        vec_t v;
        v.kind = 2'd0; v.vpn = vpn; v.asid = asid; v.pfn = pfn;
        v.shift = sh; v.glob = g; v.attr = at; v.exp_hit = eh;
        return v;
    endfunction

    // Model search: first valid slot covering the page in the right context.
    function automatic int m_find(logic [19:0] vpn, logic [7:0] ctx);
        for (int i = 0; i < E; i++) begin
            if (m_valid[i] && ((m_vpn[i] >> m_shift[i]) == (vpn >> m_shift[i])) &&
                (m_glob[i] || m_asid[i] == ctx))
                return i;
        end
        return -1;
    endfunction

    task automatic m_flush();
        for (int i = 0; i < E; i++) begin
            m_valid[i] = 0; m_glob[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0;
            m_asid[i] = 0; m_shift[i] = 0; m_attr[i] = 0;
        end
    endtask

    task automatic m_move(int dst, int src);
        m_valid[dst] = m_valid[src]; m_glob[dst] = m_glob[src];
        m_vpn[dst] = m_vpn[src]; m_pfn[dst] = m_pfn[src];
        m_asid[dst] = m_asid[src]; m_shift[dst] = m_shift[src];
        m_attr[dst] = m_attr[src];
    endtask

    task automatic m_fill(vec_t f);
        for (int i = E - 1; i > 0; i--) m_move(i, i - 1);
        m_valid[0] = 1; m_glob[0] = f.glob; m_vpn[0] = f.vpn; m_pfn[0] = f.pfn;
        m_asid[0] = f.asid; m_shift[0] = f.shift; m_attr[0] = f.attr;
    endtask

    task automatic m_promote(int x);
        logic        v, g;
        logic [19:0] vp, pf;
        logic [7:0]  as, at;
        logic [2:0]  sh;
        v = m_valid[x]; g = m_glob[x]; vp = m_vpn[x]; pf = m_pfn[x];
        as = m_asid[x]; at = m_attr[x]; sh = m_shift[x];
        for (int i = x; i > 0; i--) m_move(i, i - 1);
        m_valid[0] = v; m_glob[0] = g; m_vpn[0] = vp; m_pfn[0] = pf;
        m_asid[0] = as; m_attr[0] = at; m_shift[0] = sh;
    endtask

    // Compare the combinational lookup outputs against the model.
    task automatic cmp_lookup(logic [19:0] vpn, logic [7:0] ctx, string tag);
        int mi;
        mi = m_find(vpn, ctx);
        chk("R2", {tag, " hit"}, lk_hit_o, (mi >= 0));
        if (mi >= 0) begin
            chk("R1", {tag, " idx"}, lk_idx_o, mi);
            chk("R1", {tag, " pfn"}, lk_pfn_o, m_pfn[mi]);
            chk("R6", {tag, " attr"}, lk_attr_o, m_attr[mi]);
        end else begin
            chk("R3", {tag, " miss outputs"}, {lk_idx_o, lk_pfn_o, lk_attr_o}, 0);
        end
    endtask

    task automatic idle();
        flush_i = 0; fill_i = 0; lk_valid_i = 0;
        fill_vpn_i = 0; fill_asid_i = 0; fill_pfn_i = 0; fill_shift_i = 0;
        fill_global_i = 0; fill_attr_i = 0; lk_vpn_i = 0; lk_ctx_i = 0;
    endtask

    // Side-effect-free probe with lk_valid_i low (R10).
    task automatic probe(logic [19:0] vpn, logic [7:0] ctx, string tag);
        lk_valid_i = 0; lk_vpn_i = vpn; lk_ctx_i = ctx;
        #1;
        cmp_lookup(vpn, ctx, tag);
    endtask

    // Probe every live model slot; the order must match slot for slot.
    task automatic check_order(string tag);
        @(negedge clk);
        for (int i = 0; i < E; i++) begin
            if (m_valid[i]) probe(m_vpn[i], m_asid[i], {tag, " order R4 R6 R10"});
        end
    endtask

    // One cycle of stimulus; outputs checked before the edge, model after it.
    task automatic step(vec_t lk, vec_t fl, bit lkv, bit fil, bit flu, string tag);
        int mi;
        @(negedge clk);
        lk_valid_i = lkv; lk_vpn_i = lk.vpn; lk_ctx_i = lk.asid;
        fill_i = fil; fill_vpn_i = fl.vpn; fill_asid_i = fl.asid; fill_pfn_i = fl.pfn;
        fill_shift_i = fl.shift; fill_global_i = fl.glob; fill_attr_i = fl.attr;
        flush_i = flu;
        #1;
        mi = m_find(lk.vpn, lk.asid);
        if (lkv) begin
            cmp_lookup(lk.vpn, lk.asid, tag);
            chk("R2", {tag, " table hit"}, lk_hit_o, lk.exp_hit);
        end
        @(posedge clk);
        if (flu) m_flush();
        else if (fil) m_fill(fl);
        else if (lkv && mi > WIN) m_promote(mi);
        #1;
        idle();
    endtask

    initial begin
        vec_t z;
        z = mk(0, 0, 0, 0, 0, 0, 0);
        idle();
        m_flush();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R9: table empty after reset.
        probe(20'h0, 8'h0, "R9 reset");
        chk("R9", "reset hit", lk_hit_o, 0);

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            case (VEC[v].kind)
                2'd0:    step(VEC[v], z, 1, 0, 0, $sformatf("vec%0d lookup", v));
                2'd1:    step(z, VEC[v], 0, 1, 0, $sformatf("vec%0d fill", v));
                default: step(z, z, 0, 0, 1, $sformatf("vec%0d flush", v));
            endcase
            check_order($sformatf("vec%0d", v));
        end

        // R1: duplicate translations, newest (lowest slot) wins.
        step(z, mk(20'h400, 8'h02, 20'h00111, 0, 0, 8'h01, 0), 0, 1, 0, "R1 dupA");
        step(z, mk(20'h400, 8'h02, 20'h00222, 0, 0, 8'h02, 0), 0, 1, 0, "R1 dupB");
        @(negedge clk);
        probe(20'h400, 8'h02, "R1 dup");
        chk("R1", "dup pfn", lk_pfn_o, 20'h00222);
        chk("R1", "dup idx", lk_idx_o, 0);

        // Fill to full, then collide a deep hit with a fill (R8).
        for (int k = 0; k < 6; k++)
            step(z, mk(20'h500 + 20'(k), 8'h04, 20'h00C00 + 20'(k), 0, 0, 8'(k), 0), 0, 1, 0, "R8 prefill");
        step(mk(20'h400, 8'h02, 0, 0, 0, 0, 1), mk(20'h600, 8'h04, 20'h00D00, 0, 0, 8'h66, 0),
             1, 1, 0, "R8 fill+promote");
        check_order("R8 collide");
        @(negedge clk);
        probe(20'h400, 8'h02, "R8 dupB moved down");
        chk("R8", "promotion dropped idx", lk_idx_o, 7);

        // R5: hit at slot 0 keeps order.
        step(mk(20'h600, 8'h04, 0, 0, 0, 0, 1), z, 1, 0, 0, "R5 slot0");
        check_order("R5 slot0");

        // R10: probe of a deep entry across a clock edge does not reorder.
        @(negedge clk);
        probe(20'h500, 8'h04, "R10 deep probe");
        @(posedge clk);
        @(negedge clk);
        probe(20'h500, 8'h04, "R10 deep probe again");
        chk("R10", "deep probe idx", lk_idx_o, 6);

        // R8: flush beats fill in the same cycle.
        step(z, mk(20'h700, 8'h04, 20'h00E00, 0, 0, 8'h77, 0), 0, 1, 1, "R8 flush+fill");
        @(negedge clk);
        probe(20'h700, 8'h04, "R8 flush wins");
        chk("R8", "flush wins hit", lk_hit_o, 0);
        probe(20'h600, 8'h04, "R7 after flush");
        chk("R7", "after flush hit", lk_hit_o, 0);

        summary();
    end

endmodule